// File: doc/BRIEF.md
# Erased-Sector Detector

A sector that the error decoder cannot repair may simply be a freshly erased one. In an erased sector both the payload and the stored check bytes read back as all ones, and the check bytes of an all-ones payload are not all ones, so the decoder rejects it. This block tells the two cases apart. It receives the sector one byte per beat. Each beat carries a tag that says whether the byte belongs to the payload group or to the check-byte group. The block counts the bits that read as zero in each group.

A beat with `in_start` opens a sector. The sector is evaluated only if `in_dec_fail` is high in that cycle, which means the decoder reported more errors than it can correct. Each group count saturates just above the threshold, so the counters stay narrow whatever the sector length. One cycle after the final beat the block gives its verdict:
- **Erased:** the combined count is within the threshold. The block reports the payload zero count, and raises a fill request when the payload has to be overwritten with all ones.
- **Uncorrectable:** the combined count is above the threshold.

Rewriting the buffer is left to the consumer.

Top module: `erased_sector_detect`

## Requirements
- R1: After reset, `o_valid`, `o_erased`, `o_uncorrectable` and `o_fill_ones` are 0 and `o_data_zeros` is 0.
- R2: A sector is evaluated only when `in_dec_fail` is 1 in the `in_start` cycle. Otherwise its beats are ignored and `o_valid` stays 0 until the next start.
- R3: Each accepted beat adds the number of 0 bits in `in_byte` to the payload count (`in_is_ecc`=0) or to the check count (`in_is_ecc`=1). Each count saturates at THRESH+1 (9 by default). `o_data_zeros` shows the payload count.
- R4: While `o_valid` is 1, `o_erased` is 1 exactly when payload count plus check count is at most THRESH (8 by default).
- R5: While `o_valid` is 1, `o_uncorrectable` is 1 exactly when the combined count exceeds THRESH. Exactly one of `o_erased` and `o_uncorrectable` is 1.
- R6: `o_valid` rises in the cycle after an accepted beat with `in_last`=1. The verdict and count then stay unchanged, and later beats are ignored, until the next `in_start`, which clears `o_valid`.
- R7: `o_fill_ones` is 1 exactly when `o_erased` is 1 and `o_data_zeros` is nonzero.
- R8: A sector whose bytes are all 0xFF yields erased, a count of 0, and no fill request.
- R9: The beat presented with `in_start` is the first byte of the new sector and is counted if `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_start | input | 1 | Opens a sector; clears counts and verdict |
| in_dec_fail | input | 1 | Decoder overflow flag, sampled with `in_start` |
| in_valid | input | 1 | Byte beat present |
| in_byte | input | BYTE_W | Byte read from the sector |
| in_is_ecc | input | 1 | 0: payload byte, 1: check byte |
| in_last | input | 1 | Marks the final beat of the sector |
| o_valid | output | 1 | Verdict available |
| o_erased | output | 1 | Sector treated as erased |
| o_uncorrectable | output | 1 | Sector is a genuine failure |
| o_data_zeros | output | CW | Saturated payload zero count |
| o_fill_ones | output | 1 | Consumer must overwrite the payload with all ones |

## Verification
The assertions assume that the inputs are known, and that `in_start` marks a sector boundary rather than toggling in the middle of one. Under that assumption, the hold-after-last property and the one-hot verdict property describe complete sectors only. The stimulus sends whole sectors of 525 beats, each opened by a single start pulse, with inputs driven on the falling edge. Beats sent after the last beat and sectors that are not armed carry zero-heavy bytes, so a counting leak would show up in the compared outputs. The reference model recomputes the zero counts from the bytes with integer arithmetic and compares every output on every cycle.

// File: rtl/ersd_pkg.sv
package ersd_pkg;
   typedef enum logic {
      GRP_DATA = 1'b0,
      GRP_ECC  = 1'b1
   } grp_e;

   function automatic int bits_for(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/zero_popcnt.sv
module zero_popcnt #(
   parameter int W  = 8,
   parameter int OW = 4
) (
   input  logic [W-1:0]  bits_in,
   output logic [OW-1:0] zeros
);
   if (W < 1) begin : g_bad_w
      $error("zero_popcnt: W must be positive");
   end
   if ((1 << OW) <= W) begin : g_bad_ow
      $error("zero_popcnt: OW too narrow for W");
   end

   logic [W-1:0] inv;

   for (genvar i = 0; i < W; i++) begin : g_inv
      assign inv[i] = ~bits_in[i];
   end

   always_comb begin
      zeros = '0;
      for (int k = 0; k < W; k++) begin
         zeros = zeros + OW'(inv[k]);
      end
   end
endmodule

// File: rtl/sat_acc.sv
module sat_acc #(
   parameter int AW  = 4,
   parameter int CW  = 4,
   parameter int SAT = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          en,
   input  logic [AW-1:0] add,
   output logic [CW-1:0] cnt
);
   localparam int SW = ersd_pkg::bits_for(SAT + (1 << AW));

   if (SAT >= (1 << CW)) begin : g_bad_cw
      $error("sat_acc: CW too narrow for SAT");
   end

   logic [SW-1:0] base;
   logic [SW-1:0] sum;
   logic [CW-1:0] nxt;

   always_comb begin
      base = clear ? '0 : SW'(cnt);
      sum  = base + SW'(add);
      nxt  = (sum > SW'(SAT)) ? CW'(SAT) : CW'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (en)     cnt <= nxt;
      else if (clear)  cnt <= '0;
   end

   // R3
   cnt_le_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(SAT));

   // R3
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clear && cnt == CW'(SAT)) |=> cnt == CW'(SAT));
endmodule

// File: rtl/erased_sector_detect.sv
module erased_sector_detect
   import ersd_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int THRESH = 8,
   localparam int SAT = THRESH + 1,
   localparam int CW  = bits_for(SAT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_start,
   input  logic              in_dec_fail,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_is_ecc,
   input  logic              in_last,
   output logic              o_valid,
   output logic              o_erased,
   output logic              o_uncorrectable,
   output logic [CW-1:0]     o_data_zeros,
   output logic              o_fill_ones
);
   localparam int ZW = bits_for(BYTE_W);
   localparam int TW = bits_for(2 * SAT);

   if (THRESH < 1) begin : g_bad_thresh
      $error("erased_sector_detect: THRESH must be at least 1");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("erased_sector_detect: BYTE_W must be positive");
   end

   logic          armed;
   logic          accept;
   logic          fin;
   logic [ZW-1:0] zcnt;
   logic [CW-1:0] d_cnt;
   logic [CW-1:0] e_cnt;
   logic [TW-1:0] total;
   grp_e          grp;

   assign grp    = grp_e'(in_is_ecc);
   assign accept = in_valid && (in_start ? in_dec_fail : armed);
   assign fin    = accept && in_last;

   zero_popcnt #(.W(BYTE_W), .OW(ZW)) u_pop (
      .bits_in (in_byte),
      .zeros   (zcnt)
   );

   sat_acc #(.AW(ZW), .CW(CW), .SAT(SAT)) u_data_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (in_start),
      .en    (accept && grp == GRP_DATA),
      .add   (zcnt),
      .cnt   (d_cnt)
   );

   sat_acc #(.AW(ZW), .CW(CW), .SAT(SAT)) u_ecc_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (in_start),
      .en    (accept && grp == GRP_ECC),
      .add   (zcnt),
      .cnt   (e_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         o_valid <= 1'b0;
      end else if (in_start) begin
         armed   <= in_dec_fail && !fin;
         o_valid <= fin;
      end else if (fin) begin
         armed   <= 1'b0;
         o_valid <= 1'b1;
      end
   end

   always_comb begin
      total           = TW'(d_cnt) + TW'(e_cnt);
      o_erased        = o_valid && (total <= TW'(THRESH));
      o_uncorrectable = o_valid && (total >  TW'(THRESH));
      o_data_zeros    = d_cnt;
      o_fill_ones     = o_erased && (d_cnt != '0);
   end

   // R2
   disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_start && !in_dec_fail) |=> !o_valid);

   // R6
   last_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !in_start && in_valid && in_last) |=> o_valid);

   // R6
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !in_start) |=> (o_valid && $stable(o_data_zeros) && $stable(o_erased)));

   // R5
   verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> $onehot({o_erased, o_uncorrectable}));

   // R7
   fill_needs_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_fill_ones |-> (o_erased && o_data_zeros != '0));

   // R6
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_start && !in_last) |=> !o_valid);
endmodule

// File: tb/tb_erased_sector_detect.sv
module tb_erased_sector_detect;
   localparam int NDATA = 512;
   localparam int NECC  = 13;
   localparam int NTOT  = NDATA + NECC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_start = 1'b0;
   logic       in_dec_fail = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'hFF;
   logic       in_is_ecc = 1'b0;
   logic       in_last = 1'b0;
   logic       o_valid, o_erased, o_uncorrectable, o_fill_ones;
   logic [3:0] o_data_zeros;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 0;
   logic [7:0] sbuf [NTOT];

   int  m_d = 0, m_e = 0;
   bit  m_armed = 0, m_vld = 0;

   always #2.5 clk = ~clk;

   erased_sector_detect dut (
      .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_dec_fail(in_dec_fail),
      .in_valid(in_valid), .in_byte(in_byte), .in_is_ecc(in_is_ecc),
      .in_last(in_last), .o_valid(o_valid), .o_erased(o_erased),
      .o_uncorrectable(o_uncorrectable), .o_data_zeros(o_data_zeros),
      .o_fill_ones(o_fill_ones)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_d = 0; m_e = 0; m_armed = 0; m_vld = 0;
      end else begin
         bit acc;
         int z;
         acc = in_valid && (in_start ? in_dec_fail : m_armed);
         z = 8 - $countones(in_byte);
         if (in_start) begin
            m_d = 0; m_e = 0; m_vld = 0; m_armed = in_dec_fail;
         end
         if (acc) begin
            if (in_is_ecc) m_e = (m_e + z > 9) ? 9 : m_e + z;
            else           m_d = (m_d + z > 9) ? 9 : m_d + z;
            if (in_last) begin
               m_armed = 0; m_vld = 1;
            end
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit er;
         er = m_vld && (m_d + m_e <= 8);
         chk("R6 valid", o_valid, m_vld);
         chk("R4 erased", o_erased, er);
         chk("R5 uncorrectable", o_uncorrectable, m_vld && !er);
         chk("R3 data_zeros", o_data_zeros, m_d);
         chk("R7 fill", o_fill_ones, er && m_d != 0);
      end
   end

   task automatic clear_buf();
      for (int i = 0; i < NTOT; i++) sbuf[i] = 8'hFF;
   endtask

   task automatic send_sector(input bit fail, input int extra);
      for (int i = 0; i < NTOT; i++) begin
         @(negedge clk);
         in_start    = (i == 0);
         in_dec_fail = fail;
         in_valid    = 1'b1;
         in_byte     = sbuf[i];
         in_is_ecc   = (i >= NDATA);
         in_last     = (i == NTOT - 1);
      end
      for (int j = 0; j < extra; j++) begin
         @(negedge clk);
         in_start = 1'b0; in_valid = 1'b1; in_byte = 8'h00;
         in_is_ecc = j[0]; in_last = 1'b1;
      end
      @(negedge clk);
      in_start = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_byte = 8'hFF;
      @(negedge clk);
   endtask

   task automatic verdict(input string tag, input int v, input int er, input int dz, input int fl);
      chk({tag, " valid"}, o_valid, v);
      chk({tag, " erased"}, o_erased, er);
      chk({tag, " uncorrectable"}, o_uncorrectable, v && !er);
      chk({tag, " zeros"}, o_data_zeros, dz);
      chk({tag, " fill"}, o_fill_ones, fl);
   endtask

   initial begin
      while (!done && cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      verdict("R1", 0, 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 all-ones sector
      clear_buf();
      send_sector(1'b1, 0);
      verdict("R8", 1, 1, 0, 0);

      // R9 first byte rides with start; R4 R7 erased with fill
      clear_buf();
      sbuf[0] = 8'hFE; sbuf[10] = 8'hFC; sbuf[NDATA] = 8'hFC;
      send_sector(1'b1, 0);
      verdict("R9 R7", 1, 1, 3, 1);

      // R4 boundary: 5 + 3 = 8
      clear_buf();
      sbuf[100] = 8'hE0; sbuf[NDATA + 5] = 8'hF8;
      send_sector(1'b1, 0);
      verdict("R4", 1, 1, 5, 1);

      // R5 one past boundary: 5 + 4 = 9
      clear_buf();
      sbuf[100] = 8'hE0; sbuf[NDATA + 5] = 8'hF0;
      send_sector(1'b1, 0);
      verdict("R5", 1, 0, 5, 0);

      // R5 check bytes alone exceed the threshold
      clear_buf();
      sbuf[NDATA] = 8'h00; sbuf[NTOT - 1] = 8'hFE;
      send_sector(1'b1, 0);
      verdict("R5 ecc", 1, 0, 0, 0);

      // R3 saturation of the payload count
      for (int i = 0; i < NTOT; i++) sbuf[i] = 8'h00;
      send_sector(1'b1, 0);
      verdict("R3 sat", 1, 0, 9, 0);

      // R2 not armed: no verdict, bytes ignored
      for (int i = 0; i < NTOT; i++) sbuf[i] = 8'h0F;
      send_sector(1'b0, 0);
      verdict("R2", 0, 0, 0, 0);

      // R6 beats after last are ignored and the verdict holds
      clear_buf();
      sbuf[3] = 8'hFD;
      send_sector(1'b1, 4);
      verdict("R6 hold", 1, 1, 1, 1);
      repeat (5) @(negedge clk);
      verdict("R6 hold later", 1, 1, 1, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule